// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a serial peripheral interface master. Software reaches it through four 32-bit word registers on a simple request/response bus: a control word, a configuration word, a transmit word and a receive word. Every transfer moves exactly one byte in both directions at once. Storing a byte in the transmit register starts the shift. The controller then toggles the serial clock, drives the outgoing line and samples the incoming line. When the shift completes, the captured byte can be read from the receive register. A ready flag in the control word tells software when the engine is idle again.

Chip selects are entirely under software control: each select has its own enable bit, and transfers never touch them. The configuration word sets the clock divide ratio, the clock polarity and the clock phase. It also holds two mode bits that are stored for readback only, and a flush request bit that clears itself after a short fixed delay.

Bus rules: `req_ready` is held high, so a request is taken on every cycle in which `req_valid` is high. A read answers with `rsp_valid` and `rsp_rdata` exactly one cycle later, and the response cannot be back-pressured. Writes produce no response.

Top module: `spi_legacy_master`

## Requirements
- R1: A read request at word offset 0x0 (control), 0x4 (configuration), 0x8 (transmit) or 0xC (receive), decoded from address bits 3:2, returns `rsp_valid` high with the register value on the cycle after acceptance. `req_ready` is always high.
- R2: Control bit 1 reads 1 while the shift engine is idle. It reads 0 from the cycle after a transmit write starts a transfer until that transfer ends. After reset the control word reads 0x0000_0002.
- R3: Control bit 16+n drives chip select n: `cs_n[n]` is low while the bit is 1 and high while it is 0. Transfers never change the select lines.
- R4: A write to the transmit register while idle sends bits 7:0 of the written value, most significant bit first, in exactly 16 serial clock edges.
- R5: At the end of a transfer, the byte sampled from `miso` (first bit = bit 7) is readable in receive bits 7:0. Bits 31:8 of the receive word read 0.
- R6: Configuration bit 7 sets the clock polarity: `sck` rests at that level whenever no transfer is running. Configuration bit 6 sets the phase. With phase 0, data is sampled on leading edges and changed on trailing edges. With phase 1, data is changed on leading edges and sampled on trailing edges.
- R7: Configuration bits 4:0 hold a divide ratio P. Each half period of `sck` lasts ceil(P/2) clock cycles, and a P of 0 or 1 behaves as 2.
- R8: Writing 1 to configuration bit 9 makes it read 1. It then returns to 0 by itself within FLUSH_CYC cycles, and the other configuration fields are left unchanged.
- R9: Configuration bits 5 and 17 are stored and read back as written, but have no effect on the transfer: a byte still moves with 16 edges.
- R10: A transmit write that arrives while a transfer is running is ignored. The running byte, its timing and the later ready state are unchanged, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to devices |
| miso | input | 1 | Serial data from devices |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A bench-side serial device model shifts a chosen byte back on `miso` and captures `mosi`, and a scoreboard pairs each queued transmit/receive byte pair with what appears on the wire. All four clock modes are used. Byte patterns with alternating bits, single set bits at each end, all ones and all zeros separate MSB-first from LSB-first order and expose sampling on the wrong edge. Divide ratios 0, 3, 4, 6 and 31 separate the divide-by-two floor from rounding up on odd ratios. A transmit write issued in the middle of a transfer shows whether that write is dropped or is allowed to corrupt or restart the byte.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;

  localparam int REG_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_CFG  = 2'd1,
    RSEL_TX   = 2'd2,
    RSEL_RX   = 2'd3
  } reg_sel_e;

  localparam int CTRL_RDY_BIT  = 1;
  localparam int CTRL_CS_LSB   = 16;

  localparam int CFG_DIV_LSB   = 0;
  localparam int CFG_DIV_W     = 5;
  localparam int CFG_LEN_BIT   = 5;
  localparam int CFG_PHA_BIT   = 6;
  localparam int CFG_POL_BIT   = 7;
  localparam int CFG_FLUSH_BIT = 9;
  localparam int CFG_FIFO_BIT  = 17;

  typedef struct packed {
    logic [CFG_DIV_W-1:0] div;
    logic                 pha;
    logic                 pol;
  } shift_cfg_t;

endpackage

// File: rtl/spi_lm_flush_timer.sv
module spi_lm_flush_timer #(
  parameter int FLUSH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic pending_o
);
  localparam int CW = $clog2(FLUSH_CYC + 1) + 1;

  logic [CW-1:0] remain;
  logic [CW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      remain    <= '0;
    end else if (set_i) begin
      pending_o <= 1'b1;
      remain    <= CW'(FLUSH_CYC - 1);
    end else if (pending_o) begin
      if (remain == '0) pending_o <= 1'b0;
      else              remain    <= remain - 1'b1;
    end
  end

  // cycle age of the current flush request, used by the check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (set_i)     age <= '0;
    else if (pending_o) age <= age + 1'b1;
  end

  // R8: the request bit never survives FLUSH_CYC cycles
  a_r8_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |-> (age < CW'(FLUSH_CYC)));

endmodule

// File: rtl/spi_lm_shifter.sv
module spi_lm_shifter
  import spi_lm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  shift_cfg_t        cfg_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_done_o
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);

  logic [CFG_DIV_W-1:0] half_c, half_q, hcnt;
  logic [EW-1:0]        ecnt;
  logic                 tog, pha_q, pol_q;
  logic [BYTE_W-1:0]    out_q, in_q;
  logic                 edge_now, lead, sample_edge;

  // half period in input clocks: ceil(P/2), floor of one
  always_comb begin
    if (cfg_i.div < CFG_DIV_W'(2)) half_c = CFG_DIV_W'(1);
    else half_c = CFG_DIV_W'((6'(cfg_i.div) + 6'd1) >> 1);
  end

  assign edge_now    = busy_o && (hcnt == half_q - 1'b1);
  assign lead        = ~ecnt[0];
  assign sample_edge = (lead == ~pha_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      half_q    <= CFG_DIV_W'(1);
      hcnt      <= '0;
      ecnt      <= '0;
      tog       <= 1'b0;
      pha_q     <= 1'b0;
      pol_q     <= 1'b0;
      out_q     <= '0;
      in_q      <= '0;
      rx_done_o <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        half_q <= half_c;
        hcnt   <= '0;
        ecnt   <= '0;
        tog    <= 1'b0;
        pha_q  <= cfg_i.pha;
        pol_q  <= cfg_i.pol;
        out_q  <= tx_byte_i;
      end else if (busy_o) begin
        if (edge_now) begin
          hcnt <= '0;
          tog  <= ~tog;
          ecnt <= ecnt + 1'b1;
          if (sample_edge)       in_q  <= {in_q[BYTE_W-2:0], miso_i};
          else if (ecnt != '0)   out_q <= {out_q[BYTE_W-2:0], 1'b0};
          if (ecnt == EW'(EDGES - 1)) begin
            busy_o    <= 1'b0;
            rx_done_o <= 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  assign sck_o     = busy_o ? (pol_q ^ tog) : cfg_i.pol;
  assign mosi_o    = out_q[BYTE_W-1];
  assign rx_byte_o = in_q;

  // R2: the engine only becomes busy because of an accepted start
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R6: the clock sits at the idle level when a transfer begins
  a_r6_no_start_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> (sck_o == $past(cfg_i.pol)));

  // R7: the serial clock only moves on a half-period boundary
  a_r7_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(edge_now)) |-> $stable(sck_o));

endmodule

// File: rtl/spi_lm_regs.sv
module spi_lm_regs
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int FLUSH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        word_sel,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  input  logic              engine_busy,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_done,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output shift_cfg_t        shift_cfg,
  output logic [NUM_CS-1:0] cs_en
);
  reg_sel_e          sel;
  logic              wr, rd, flush_set, flush_pend;
  logic              len_q, fifo_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic [REG_W-1:0]  rdata_c;

  assign sel       = reg_sel_e'(word_sel);
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign start     = wr && (sel == RSEL_TX) && !engine_busy;
  assign tx_byte   = req_wdata[BYTE_W-1:0];
  assign flush_set = wr && (sel == RSEL_CFG) && req_wdata[CFG_FLUSH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en     <= '0;
      shift_cfg <= '0;
      len_q     <= 1'b0;
      fifo_q    <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else begin
      if (wr && sel == RSEL_CTRL) cs_en <= req_wdata[CTRL_CS_LSB +: NUM_CS];
      if (wr && sel == RSEL_CFG) begin
        shift_cfg.div <= req_wdata[CFG_DIV_LSB +: CFG_DIV_W];
        shift_cfg.pha <= req_wdata[CFG_PHA_BIT];
        shift_cfg.pol <= req_wdata[CFG_POL_BIT];
        len_q         <= req_wdata[CFG_LEN_BIT];
        fifo_q        <= req_wdata[CFG_FIFO_BIT];
      end
      if (start)   tx_q <= tx_byte;
      if (rx_done) rx_q <= rx_byte;
    end
  end

  spi_lm_flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (flush_set),
    .pending_o(flush_pend)
  );

  always_comb begin
    rdata_c = '0;
    unique case (sel)
      RSEL_CTRL: begin
        rdata_c[CTRL_RDY_BIT]               = !engine_busy;
        rdata_c[CTRL_CS_LSB +: NUM_CS]      = cs_en;
      end
      RSEL_CFG: begin
        rdata_c[CFG_DIV_LSB +: CFG_DIV_W]   = shift_cfg.div;
        rdata_c[CFG_LEN_BIT]                = len_q;
        rdata_c[CFG_PHA_BIT]                = shift_cfg.pha;
        rdata_c[CFG_POL_BIT]                = shift_cfg.pol;
        rdata_c[CFG_FLUSH_BIT]              = flush_pend;
        rdata_c[CFG_FIFO_BIT]               = fifo_q;
      end
      RSEL_TX:  rdata_c[BYTE_W-1:0] = tx_q;
      RSEL_RX:  rdata_c[BYTE_W-1:0] = rx_q;
      default:  rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_c;
    end
  end

  // R1: every response answers a read taken on the previous cycle
  a_r1_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));

  // R5: receive word upper bits stay zero
  a_r5_rx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(sel == RSEL_RX)) |-> (rsp_rdata[REG_W-1:BYTE_W] == '0));

  // R10: a transmit write during a transfer leaves the held byte alone
  a_r10_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && sel == RSEL_TX && engine_busy) |-> $stable(tx_q));

endmodule

// File: rtl/spi_legacy_master.sv
module spi_legacy_master
  import spi_lm_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int FLUSH_CYC = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic              busy, start, rx_done;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [NUM_CS-1:0] cs_en;
  shift_cfg_t        shift_cfg;

  assign req_ready = 1'b1;

  spi_lm_regs #(.NUM_CS(NUM_CS), .FLUSH_CYC(FLUSH_CYC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .word_sel   (req_addr[3:2]),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .engine_busy(busy),
    .rx_byte    (rx_byte),
    .rx_done    (rx_done),
    .start      (start),
    .tx_byte    (tx_byte),
    .shift_cfg  (shift_cfg),
    .cs_en      (cs_en)
  );

  spi_lm_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .tx_byte_i(tx_byte),
    .cfg_i    (shift_cfg),
    .miso_i   (miso),
    .busy_o   (busy),
    .sck_o    (sck),
    .mosi_o   (mosi),
    .rx_byte_o(rx_byte),
    .rx_done_o(rx_done)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = ~cs_en[i];
  end

  // R3: selects only move after a control write
  a_r3_cs_software_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write && req_addr[3:2] == 2'd0) |-> $stable(cs_n));

endmodule

// File: tb/spi_legacy_master_bench.sv
module spi_legacy_master_bench;
  localparam int NCS   = 2;
  localparam int FLUSH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, miso = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, sck, mosi;
  logic [31:0] rsp_rdata;
  logic [NCS-1:0] cs_n;

  int checks = 0, errors = 0, cyc = 0;

  typedef struct { logic [7:0] tx; logic [7:0] rx; } exp_t;
  exp_t exp_q[$];

  // device model state
  logic       armed = 1'b0, sl_pol = 1'b0, sl_pha = 1'b0;
  logic [7:0] sl_byte = '0, rcv = '0;
  int         idx = 0, edges = 0, last_cyc = 0, bad_gap = 0, sl_h = 1;

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  spi_legacy_master #(.NUM_CS(NCS), .FLUSH_CYC(FLUSH), .ADDR_W(4)) u_spi_legacy_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: serial device model plus scoreboard pop
  always @(sck) begin
    logic lead;
    if (armed) begin
      lead = (sck != sl_pol);
      if (edges > 0 && (cyc - last_cyc) != sl_h) bad_gap++;
      last_cyc = cyc;
      edges++;
      if (lead == !sl_pha) rcv = {rcv[6:0], mosi};
      else if (idx >= 0) begin miso = sl_byte[idx]; idx--; end
      if (edges == 16) begin
        armed = 1'b0;
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected transfer", 32'(rcv), 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rcv == e.tx, "R4 mosi byte MSB first", 32'(rcv), 32'(e.tx));
          check(bad_gap == 0, "R7 half period length", 32'(bad_gap), 32'h0);
        end
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && req_ready === 1'b1, "R1 response next cycle",
          32'(rsp_valid), 32'h1);
    d = rsp_rdata;
  endtask

  function automatic int half_of(input int p);
    return (p < 2) ? 1 : (p + 1) / 2;
  endfunction

  // driver: configure, queue expectation, run one byte
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input bit pha,
                      input bit pol, input int div, input bit inject);
    logic [31:0] d;
    int tries;
    bus_write(4'h4, 32'(div) | (32'(pha) << 6) | (32'(pol) << 7));
    @(negedge clk);
    check(sck == pol, "R6 idle clock level", 32'(sck), 32'(pol));
    sl_pol = pol; sl_pha = pha; sl_byte = rx; sl_h = half_of(div);
    edges = 0; bad_gap = 0; rcv = '0;
    if (!pha) begin miso = rx[7]; idx = 6; end
    else begin miso = 1'b0; idx = 7; end
    exp_q.push_back('{tx: tx, rx: rx});
    armed = 1'b1;
    bus_write(4'h8, {24'hABCDEF, tx});
    if (inject) bus_write(4'h8, {24'h0, ~tx});
    bus_read(4'h0, d);
    check(d[1] == 1'b0, "R2 ready low while shifting", d, 32'h0);
    tries = 0;
    do begin bus_read(4'h0, d); tries++; end while (!d[1] && tries < 2000);
    check(d[1] == 1'b1, "R2 ready returns", d, 32'h2);
    bus_read(4'h0, d);
    check(d[1] == 1'b1, "R10 no follow-on transfer", d, 32'h2);
    bus_read(4'hC, d);
    check(d == {24'h0, rx}, "R5 received byte", d, {24'h0, rx});
    check(exp_q.size() == 0 && edges == 16, "R4 sixteen edges", 32'(edges), 32'd16);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    bus_read(4'h0, d); check(d == 32'h2, "R2 reset control word", d, 32'h2);
    bus_read(4'h4, d); check(d == 32'h0, "R1 reset configuration", d, 32'h0);
    bus_read(4'hC, d); check(d == 32'h0, "R5 reset receive", d, 32'h0);
    check(cs_n == 2'b11 && sck == 1'b0, "R3 reset selects idle", {30'h0, cs_n}, 32'h3);
    // R3 select 0 by software
    bus_write(4'h0, 32'h0001_0000);
    @(negedge clk);
    check(cs_n == 2'b10, "R3 select 0 asserted", {30'h0, cs_n}, 32'h2);
    bus_read(4'h0, d); check(d == 32'h0001_0002, "R3 control readback", d, 32'h0001_0002);
    // modes, patterns and ratios
    xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 4, 1'b0);
    xfer(8'h81, 8'h7E, 1'b1, 1'b0, 0, 1'b0);
    xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 3, 1'b0);
    xfer(8'h01, 8'h80, 1'b1, 1'b1, 31, 1'b0);
    check(cs_n == 2'b10, "R3 selects untouched by transfers", {30'h0, cs_n}, 32'h2);
    // R10 write during a transfer
    xfer(8'h96, 8'h69, 1'b0, 1'b0, 6, 1'b1);
    bus_read(4'h8, d); check(d == 32'h96, "R10 held transmit byte", d, 32'h96);
    // R9 stored-only bits
    bus_write(4'h4, 32'h0002_0022);
    bus_read(4'h4, d); check(d == 32'h0002_0022, "R9 mode bits readback", d, 32'h0002_0022);
    exp_q.push_back('{tx: 8'hFF, rx: 8'h00});
    sl_pol = 1'b0; sl_pha = 1'b0; sl_byte = 8'h00; sl_h = 1;
    edges = 0; bad_gap = 0; rcv = '0; miso = 1'b0; idx = 6; armed = 1'b1;
    bus_write(4'h8, 32'hFF);
    repeat (40) @(negedge clk);
    bus_read(4'hC, d); check(d == 32'h0, "R9 byte transfer unaffected", d, 32'h0);
    check(exp_q.size() == 0 && edges == 16, "R9 sixteen edges", 32'(edges), 32'd16);
    // R8 flush
    bus_write(4'h4, 32'h0000_0202);
    bus_read(4'h4, d); check(d == 32'h0000_0202, "R8 flush reads set", d, 32'h202);
    repeat (FLUSH) @(negedge clk);
    bus_read(4'h4, d); check(d == 32'h0000_0002, "R8 flush cleared", d, 32'h2);
    // R3 switch selects
    bus_write(4'h0, 32'h0002_0000);
    @(negedge clk);
    check(cs_n == 2'b01, "R3 select 1 only", {30'h0, cs_n}, 32'h1);
    bus_write(4'h0, 32'h0);
    @(negedge clk);
    check(cs_n == 2'b11, "R3 selects released", {30'h0, cs_n}, 32'h3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule